// File: doc/BRIEF.md
# Noise Shift-Register Generator

This block produces the pseudorandom bit of a noise sound channel. A 15-bit shift register moves one place towards its high end on every step. The bit that enters at the bottom is the inverse of the XOR of two register bits: bit 7, and one of eight tap bits chosen by a 3-bit code. A down-counting step timer sets the step rate. It reloads with forty times the distance of the channel's 11-bit frequency word from 2048, so a higher frequency word gives faster steps.

Two strobes reseed the register. A write of the tap control byte takes a new tap code. A channel start reloads the step timer. In both cases the register is cleared and advanced once in the same clock, so it always resumes from the value 1. While the channel enable is low, the register and the timer keep their values. The channel output is the low register bit. A one-cycle step pulse marks each advance, so downstream logic can count steps or latch the new bit.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `noise_bit` and `step_pulse` are both 0.
- R2: On each step, register bits 13:0 move up to bits 14:1 and the old bit 14 is lost. The new bit 0 is NOT(bit 7 XOR the tapped bit).
- R3: The tap code is `tap_wdata[6:4]`. Codes 0 to 7 select register bits 14, 10, 13, 4, 8, 6, 9 and 11 in that order. Bits 7 and 3:0 of the write data have no effect.
- R4: While enabled, timed steps are exactly 40*(2048 - F) enabled clocks apart. F is the value on `freq` at the edge where the timer reloads, so a new frequency takes effect only at the next reload.
- R5: A cycle with `tap_wr` high clears the register and steps it once, so the register holds 1 in the following cycle. The new tap code is used from that edge on, and the step timer is not disturbed. A timed step that falls on the same edge is absorbed, giving a single advance.
- R6: A cycle with `start` high seeds the register to 1 in the same way and reloads the step timer with the full period. The next timed step follows 40*(2048 - F) enabled clocks later. This holds whether `chan_en` is high or low in that cycle.
- R7: While `chan_en` is low and no strobe is present, the register and the step timer hold their values. Disabled clocks postpone the next timed step one cycle each.
- R8: `step_pulse` is high for exactly one cycle after every edge at which the register advances, whether by a seed or a timed step, and is low otherwise.
- R9: `noise_bit` always equals bit 0 of the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; low freezes register and timer |
| freq | input | 11 | Channel frequency word F |
| start | input | 1 | Channel-start strobe: seed register, reload timer |
| tap_wr | input | 1 | Tap control write strobe |
| tap_wdata | input | 8 | Tap control write data, tap code in bits 6:4 |
| noise_bit | output | 1 | Low bit of the shift register |
| step_pulse | output | 1 | One-cycle pulse after each register advance |

## Verification
Every result appears one register stage after its cause. A seed from `start` or `tap_wr` shows on `noise_bit` and `step_pulse` in the cycle after the strobe edge. A timed step shows one full period after the start edge, pushed back by one cycle for each disabled clock. The driver predicts the due cycle of each advance from the strobes, the enable and the frequency it applies. It queues that cycle with the expected bit. The monitor samples on the falling edge. It reports a pulse that arrives with no entry due in that cycle, an entry whose cycle passes with no pulse, and a bit that differs from the prediction.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;
  localparam int LFSR_W = 15;
  localparam int TAP_W  = 3;
  localparam int FB_BIT = 7;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [TAP_W-1:0]  tap_code_t;

  // Register bit compared against bit FB_BIT for each tap code.
  function automatic int unsigned tap_index(tap_code_t code);
    case (code)
      3'd0:    return 14;
      3'd1:    return 10;
      3'd2:    return 13;
      3'd3:    return 4;
      3'd4:    return 8;
      3'd5:    return 6;
      3'd6:    return 9;
      default: return 11;
    endcase
  endfunction

  // One advance: shift towards the top, inverted XOR feedback at the bottom.
  function automatic lfsr_t lfsr_step(lfsr_t cur, tap_code_t code);
    logic fb;
    fb = ~(cur[FB_BIT] ^ cur[tap_index(code)]);
    return {cur[LFSR_W-2:0], fb};
  endfunction
endpackage

// File: rtl/noise_tap_reg.sv
module noise_tap_reg
  import noise_lfsr_pkg::*;
#(
  parameter int WDATA_W = 8,
  parameter int TAP_LSB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [WDATA_W-1:0] wdata,
  output tap_code_t          tap_eff
);
  tap_code_t tap_q;
  tap_code_t field;
  logic      unused_ctl_bits;

  assign field           = wdata[TAP_LSB +: TAP_W];
  assign unused_ctl_bits = ^{wdata[WDATA_W-1:TAP_LSB+TAP_W], wdata[TAP_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)  tap_q <= '0;
    else if (wr) tap_q <= field;
  end

  // A write takes effect for the seeding step in the same cycle.
  assign tap_eff = wr ? field : tap_q;
endmodule

// File: rtl/noise_step_timer.sv
module noise_step_timer #(
  parameter int FREQ_W = 11,
  parameter int MUL    = 40,
  parameter int CNT_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              reload,
  input  logic [FREQ_W-1:0] freq,
  output logic              expire,
  output logic [CNT_W-1:0]  count
);
  function automatic logic [CNT_W-1:0] period_of(logic [FREQ_W-1:0] f);
    return CNT_W'(MUL * ((1 << FREQ_W) - int'(f)));
  endfunction

  logic [CNT_W-1:0] period;
  assign period = period_of(freq);
  assign expire = en && !reload && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (reload) count <= period;
    else if (en) begin
      if (expire) count <= period;
      else        count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
  import noise_lfsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      seed,
  input  logic      advance,
  input  tap_code_t tap,
  output lfsr_t     lfsr_q,
  output logic      step_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q     <= '0;
      step_pulse <= 1'b0;
    end else begin
      if (seed)         lfsr_q <= lfsr_step('0, tap);
      else if (advance) lfsr_q <= lfsr_step(lfsr_q, tap);
      step_pulse <= seed | advance;
    end
  end
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_lfsr_pkg::*;
#(
  parameter int FREQ_W  = 11,
  parameter int MUL     = 40,
  parameter int WDATA_W = 8,
  parameter int TAP_LSB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic [FREQ_W-1:0]  freq,
  input  logic               start,
  input  logic               tap_wr,
  input  logic [WDATA_W-1:0] tap_wdata,
  output logic               noise_bit,
  output logic               step_pulse
);
  localparam int CNT_W = $clog2(MUL * (2 ** FREQ_W) + 1);

  // Named internal events, visible to the bound checker.
  logic             seed_evt;
  logic             timer_expire;
  lfsr_t            lfsr_q;
  tap_code_t        tap_eff;
  logic [CNT_W-1:0] tmr_cnt;

  assign seed_evt = start | tap_wr;

  noise_tap_reg #(.WDATA_W(WDATA_W), .TAP_LSB(TAP_LSB)) u_tap (
    .clk(clk), .rst_n(rst_n), .wr(tap_wr), .wdata(tap_wdata), .tap_eff(tap_eff)
  );

  noise_step_timer #(.FREQ_W(FREQ_W), .MUL(MUL), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(chan_en), .reload(start), .freq(freq),
    .expire(timer_expire), .count(tmr_cnt)
  );

  noise_lfsr_core u_core (
    .clk(clk), .rst_n(rst_n), .seed(seed_evt), .advance(timer_expire),
    .tap(tap_eff), .lfsr_q(lfsr_q), .step_pulse(step_pulse)
  );

  assign noise_bit = lfsr_q[0];
endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk
  import noise_lfsr_pkg::*;
#(
  parameter int FREQ_W = 11,
  parameter int MUL    = 40,
  parameter int CNT_W  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              start,
  input logic [FREQ_W-1:0] freq,
  input logic              seed_evt,
  input logic              timer_expire,
  input lfsr_t             lfsr_q,
  input tap_code_t         tap_eff,
  input logic [CNT_W-1:0]  tmr_cnt,
  input logic              step_pulse,
  input logic              noise_bit
);
  logic             tap_bit_now;
  logic [CNT_W-1:0] want_period;
  assign tap_bit_now = lfsr_q[tap_index(tap_eff)];
  assign want_period = CNT_W'(MUL * ((1 << FREQ_W) - int'(freq)));

  AST_SEED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    seed_evt |=> lfsr_q == LFSR_W'(1)); // R5
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_expire && !seed_evt) |=> lfsr_q[LFSR_W-1:1] == $past(lfsr_q[LFSR_W-2:0])); // R2
  AST_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_expire && !seed_evt) |=> lfsr_q[0] == ~($past(lfsr_q[FB_BIT]) ^ $past(tap_bit_now))); // R3
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> tmr_cnt == $past(want_period)); // R6
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !seed_evt) |=> ($stable(lfsr_q) && $stable(tmr_cnt))); // R7
  AST_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_evt || timer_expire) |=> step_pulse); // R8
  AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_evt || timer_expire) |=> !step_pulse); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cnt <= CNT_W'(MUL * (2 ** FREQ_W))); // R4
  AST_OUT_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    noise_bit == lfsr_q[0]); // R9
endmodule

bind noise_lfsr_gen noise_lfsr_chk #(.FREQ_W(FREQ_W), .MUL(MUL), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start), .freq(freq),
  .seed_evt(seed_evt), .timer_expire(timer_expire), .lfsr_q(lfsr_q),
  .tap_eff(tap_eff), .tmr_cnt(tmr_cnt), .step_pulse(step_pulse), .noise_bit(noise_bit)
);

// File: tb/sim_noise_lfsr_gen.sv
`timescale 1ns/1ps
module sim_noise_lfsr_gen;
  localparam int TAPS [8] = '{14, 10, 13, 4, 8, 6, 9, 11};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic [10:0] freq = 11'd2047;
  logic        start = 1'b0;
  logic        tap_wr = 1'b0;
  logic [7:0]  tap_wdata = 8'h00;
  logic        noise_bit, step_pulse;

  always #2 clk = ~clk;

  noise_lfsr_gen u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .freq(freq), .start(start),
    .tap_wr(tap_wr), .tap_wdata(tap_wdata), .noise_bit(noise_bit), .step_pulse(step_pulse)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; bit val; string tag; } exp_t;
  exp_t sb[$];

  // Bench-side model of the requirements.
  logic [14:0] mreg = '0;
  int          mtap = 0;
  bit          running = 0;
  int          next_due = 0;

  function automatic logic [14:0] advance_model(logic [14:0] r, int t);
    logic fb;
    fb = (r[7] == r[TAPS[t]]);
    return (r << 1) | 15'(fb);
  endfunction

  function automatic int gap_of(logic [10:0] f);
    return 40 * (2048 - int'(f));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: one clock of stimulus; predicts the advance due at the next edge.
  task automatic tick(bit en, bit st, bit tw, logic [7:0] wd, string tag);
    int  e;
    bit  timed;
    e     = cyc + 1;
    timed = running && en && !st && (e == next_due);
    chan_en = en; start = st; tap_wr = tw; tap_wdata = wd;
    if (tw) mtap = int'(wd[6:4]);
    if (st || tw) begin
      mreg = advance_model(15'd0, mtap);
      sb.push_back('{e, mreg[0], st ? "R6" : "R5"});
    end else if (timed) begin
      mreg = advance_model(mreg, mtap);
      sb.push_back('{e, mreg[0], tag});
    end
    if (st) begin
      running  = 1;
      next_due = e + gap_of(freq);
    end else if (running) begin
      if (!en)                 next_due = next_due + 1;
      else if (e == next_due)  next_due = next_due + gap_of(freq);
    end
    @(negedge clk);
  endtask

  task automatic idle(int n, bit en, string tag);
    for (int i = 0; i < n; i++) tick(en, 0, 0, 8'h00, tag);
  endtask

  // Monitor: compare pulses and bits against the queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due < cyc) begin
        checks++; errors++;
        $display("FAIL %s R8: no step_pulse at cycle %0d (actual 0, expected 1)", sb[0].tag, sb[0].due);
        void'(sb.pop_front());
      end
      if (step_pulse) begin
        checks++;
        if (sb.size() == 0 || sb[0].due != cyc) begin
          errors++;
          $display("FAIL R8: unexpected step_pulse at cycle %0d (actual 1, expected 0)", cyc);
        end else begin
          if (noise_bit !== sb[0].val) begin
            errors++;
            $display("FAIL %s R9: noise_bit at cycle %0d actual %0b expected %0b",
                     sb[0].tag, cyc, noise_bit, sb[0].val);
          end
          void'(sb.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not end (actual running, expected done)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (noise_bit !== 1'b0 || step_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset noise_bit/step_pulse actual %0b%0b expected 00", noise_bit, step_pulse);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (noise_bit !== 1'b0 || step_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset noise_bit/step_pulse actual %0b%0b expected 00", noise_bit, step_pulse);
    end
    idle(5, 0, "R7");

    // R6 and R2: start with tap code 0 at the fastest rate.
    freq = 11'd2047;
    tick(1, 1, 0, 8'h00, "R6");
    idle(800, 1, "R2");

    // R3 and R5: every tap code, with the unrelated write bits set.
    for (int t = 0; t < 8; t++) begin
      tick(1, 0, 1, {1'b1, 3'(t), 4'hA}, "R5");
      idle(700, 1, "R3");
    end

    // R4: a frequency change is taken at the next reload.
    freq = 11'd2046;
    idle(400, 1, "R4");

    // R7: a disabled stretch postpones the timed steps.
    idle(37, 0, "R7");
    idle(300, 1, "R7");

    // R5: a tap write on the same edge as a timed step.
    while (next_due != cyc + 1) tick(1, 0, 0, 8'h00, "R4");
    tick(1, 0, 1, 8'h35, "R5");
    idle(250, 1, "R5");

    // R6 and R5 together.
    tick(1, 1, 1, 8'h70, "R6");
    idle(250, 1, "R6");

    // R6 while disabled, then R7 hold before enabling.
    tick(0, 1, 0, 8'h00, "R6");
    idle(20, 0, "R7");
    idle(250, 1, "R6");

    while (sb.size() > 0) idle(1, 1, "R4");
    idle(3, 0, "R7");
    finish_run();
  end
endmodule